// File: doc/BRIEF.md
# Serial Two-Operand Adder with Set/Kill Carry Cell

This block adds two unsigned words of `WIDTH` bits, one bit position per clock, starting at the least significant bit. A load pulse captures both operands into their own shift registers, each of which moves one place toward bit 0 on every step. A start pulse then runs exactly `WIDTH` steps. On each step the sum bit goes into a result register that fills from its most significant end.

The running carry lives in a single state bit that has only two control inputs. It is set when both current operand bits are 1 (generate) and cleared when both are 0 (kill). When exactly one operand bit is 1 (propagate), neither control is active and the bit keeps its value. At the end of the run `done` rises, `sum` holds the low `WIDTH` bits of the total and `carry_out` holds bit `WIDTH`.

Top module: `serial_adder_sr`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `done`, `carry_out` and `sum` to 0 and returns to idle.
- R2: A `load` pulse captures `opnd_a` and `opnd_b`, clears the carry, the step counter, `sum` and `done`, and abandons any run in progress. `load` takes priority over `start`.
- R3: A `start` pulse accepted while idle begins a run. `done` rises at the `WIDTH`-th rising edge after the edge that accepted `start`, and stays low before that edge.
- R4: When `done` rises, `{carry_out, sum}` equals `opnd_a + opnd_b`, computed with `WIDTH+1` bits.
- R5: On a step where both current operand bits are 1, the carry becomes 1.
- R6: On a step where both current operand bits are 0, the carry becomes 0.
- R7: On a step where exactly one current operand bit is 1, the carry keeps its previous value.
- R8: The carry's set and kill controls are never active in the same cycle.
- R9: Each step shifts the bit (a XOR b XOR stored carry) into `sum[WIDTH-1]` and moves the older bits down, so after the last step `sum[0]` holds the bit computed first.
- R10: A `start` pulse that arrives during a run is ignored: it changes neither the step count nor the result.
- R11: Once `done` is high, it stays high and `sum` and `carry_out` stay unchanged until the next `load` or `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Capture the operands and clear the carry, counter and result |
| opnd_a | input | WIDTH | First operand, unsigned |
| opnd_b | input | WIDTH | Second operand, unsigned |
| start | input | 1 | Begin a run of WIDTH steps when idle |
| done | output | 1 | The result is complete and held |
| sum | output | WIDTH | Parallel result, low WIDTH bits of the total |
| carry_out | output | 1 | Carry state bit; after a run, bit WIDTH of the total |

## Verification
Several properties are checked on every cycle: that set and kill are never active together, that the carry follows generate, kill and propagate, that each new result bit is a XOR b XOR the stored carry, that a load leaves the block cleared and idle, and that `done` rises only after exactly `WIDTH` busy cycles. Other behaviour can only be shown by the bench scenarios. These cover the complete sums for patterns with long propagate chains, all-ones and all-zero operands, a start pulse dropped into the middle of a run, a load that aborts a run, and a result that stays put after completion. The bench follows the carry step by step from its own bit-level model.

// File: rtl/sadd_pkg.sv
// Shared definitions for the serial adder.
// Assumes WIDTH >= 2 wherever cnt_bits is used.
package sadd_pkg;

    // Control phase of one addition run.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } sadd_phase_e;

    // Width of a counter that holds the values 0 .. w-1.
    function automatic int cnt_bits(input int w);
        return (w > 2) ? $clog2(w) : 1;
    endfunction

endpackage

// File: rtl/sadd_opnd_shreg.sv
// Operand shift register. It loads in parallel and moves one place toward
// bit 0 on each shift, filling with 0 at the top. Only bit 0 is brought out.
// Assumes load has priority over shift.
module sadd_opnd_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         lsb
);
    logic [W-1:0] q;

    // Hold, load or shift the operand word.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= din;
        else if (shift) q <= {1'b0, q[W-1:1]};
    end

    assign lsb = q[0];
endmodule

// File: rtl/sadd_sum_shreg.sv
// Result collector. Each new bit enters at the most significant end, so after
// W shifts bit 0 holds the first bit produced. A clear empties it.
module sadd_sum_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] q
);
    // Clear or shift in one result bit.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (clear) q <= '0;
        else if (shift) q <= {bit_in, q[W-1:1]};
    end
endmodule

// File: rtl/sadd_sr_carry.sv
// Carry state bit with set and kill controls only. It holds whenever neither
// control is active. Clear wins over both controls.
// Assumes the caller never raises set and kill together.
module sadd_sr_carry (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic set,
    input  logic kill,
    output logic q
);
    // Apply clear, set or kill, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (clear) q <= 1'b0;
        else if (set)   q <= 1'b1;
        else if (kill)  q <= 1'b0;
    end
endmodule

// File: rtl/sadd_ctrl.sv
// Run controller. It counts W shift steps after an accepted start, then
// holds done. Load returns it to idle. Start is ignored during a run.
// Assumes W >= 2.
module sadd_ctrl
    import sadd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic start,
    output logic shift,
    output logic done
);
    localparam int CW = cnt_bits(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    sadd_phase_e  phase;
    logic [CW-1:0] step;

    // Phase and step counter sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            phase <= PH_IDLE;
            step  <= '0;
        end else begin
            case (phase)
                PH_RUN: begin
                    if (step == LAST) begin
                        phase <= PH_FIN;
                        step  <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                default: begin
                    if (start) begin
                        phase <= PH_RUN;
                        step  <= '0;
                    end
                end
            endcase
        end
    end

    assign shift = (phase == PH_RUN);
    assign done  = (phase == PH_FIN);
endmodule

// File: rtl/serial_adder_sr.sv
// Top of the serial adder. Two operand shift registers feed one full-adder
// slice per clock. The carry is a set/kill state bit, and results collect
// MSB-first into the sum register.
// Assumes operands are loaded before each start.
module serial_adder_sr #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             start,
    output logic             done,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    logic shift, a_bit, b_bit;
    logic carry_set, carry_kill, sum_bit;

    sadd_ctrl #(.W(WIDTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load(load), .start(start),
        .shift(shift), .done(done)
    );

    sadd_opnd_shreg #(.W(WIDTH)) u_reg_a (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
        .din(opnd_a), .lsb(a_bit)
    );

    sadd_opnd_shreg #(.W(WIDTH)) u_reg_b (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
        .din(opnd_b), .lsb(b_bit)
    );

    // Generate and kill come only from the current bit pair during a step.
    assign carry_set  = shift &  a_bit &  b_bit;
    assign carry_kill = shift & ~a_bit & ~b_bit;
    assign sum_bit    = a_bit ^ b_bit ^ carry_out;

    sadd_sr_carry u_carry (
        .clk(clk), .rst_n(rst_n), .clear(load),
        .set(carry_set), .kill(carry_kill), .q(carry_out)
    );

    sadd_sum_shreg #(.W(WIDTH)) u_sum (
        .clk(clk), .rst_n(rst_n), .clear(load), .shift(shift),
        .bit_in(sum_bit), .q(sum)
    );
endmodule

// File: rtl/sadd_checker.sv
// Cycle-level properties of the serial adder, bound to its top module.
module sadd_checker #(
    parameter int W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic load,
    input logic start,
    input logic shift,
    input logic done,
    input logic a_bit,
    input logic b_bit,
    input logic carry_set,
    input logic carry_kill,
    input logic carry_out,
    input logic sum_msb
);
    int busy_cnt;

    // Count the steps of the current run independently of the controller.
    always_ff @(posedge clk) begin
        if (!rst_n || load)          busy_cnt <= 0;
        else if (start && !shift)    busy_cnt <= 0;
        else if (shift)              busy_cnt <= busy_cnt + 1;
    end

    AST_SET_KILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(carry_set && carry_kill)); // R8
    AST_CARRY_GEN: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && a_bit && b_bit && !load) |=> carry_out); // R5
    AST_CARRY_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !a_bit && !b_bit && !load) |=> !carry_out); // R6
    AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && (a_bit != b_bit) && !load) |=> $stable(carry_out)); // R7
    AST_SUM_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (sum_msb == ($past(a_bit) ^ $past(b_bit) ^ $past(carry_out)))); // R9
    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!carry_out && !done && !shift)); // R2
    AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (busy_cnt == W)); // R3
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load && !start) |=> (done && $stable(carry_out))); // R11
endmodule

bind serial_adder_sr sadd_checker #(.W(WIDTH)) u_sadd_checker (
    .clk(clk), .rst_n(rst_n), .load(load), .start(start), .shift(shift),
    .done(done), .a_bit(a_bit), .b_bit(b_bit), .carry_set(carry_set),
    .carry_kill(carry_kill), .carry_out(carry_out), .sum_msb(sum[WIDTH-1])
);

// File: tb/serial_adder_sr_test.sv
// Scoreboard bench: the driver pushes expected totals, the monitor pops them on done.
module serial_adder_sr_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         done;
    logic [W-1:0] sum;
    logic         carry_out;

    int n_checks = 0;
    int n_fails  = 0;
    logic [W:0] exp_q[$];
    logic       done_prev = 1'b0;

    serial_adder_sr #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .load(load), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .start(start), .done(done), .sum(sum), .carry_out(carry_out)
    );

    always #10 clk = ~clk;

    task automatic check(input logic ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    // Monitor: when done rises, compare the result with the oldest expected total.
    always @(negedge clk) begin
        if (done && !done_prev) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected done", {55'd0, carry_out, sum}, 64'd0);
            end else begin
                logic [W:0] e;
                e = exp_q.pop_front();
                check({carry_out, sum} == e, "R4/R9 result", {55'd0, carry_out, sum}, {55'd0, e});
            end
        end
        done_prev = done;
    end

    // Driver: load, start, follow every step against a bit-level carry model.
    task automatic do_add(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
        logic c;
        @(negedge clk);
        load = 1'b1; opnd_a = a; opnd_b = b;
        @(negedge clk);
        load = 1'b0;
        check(!done && !carry_out && sum == '0, "R2 load clears",
              {62'd0, done, carry_out}, 64'd0);
        exp_q.push_back({1'b0, a} + {1'b0, b});
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        c = 1'b0;
        for (int i = 0; i < W; i++) begin
            start = (poke && i == 1);
            @(negedge clk);
            if (a[i] && b[i]) begin
                c = 1'b1;
                check(carry_out == c, "R5/R8 generate", {63'd0, carry_out}, {63'd0, c});
            end else if (!a[i] && !b[i]) begin
                c = 1'b0;
                check(carry_out == c, "R6/R8 kill", {63'd0, carry_out}, {63'd0, c});
            end else begin
                check(carry_out == c, "R7 propagate hold", {63'd0, carry_out}, {63'd0, c});
            end
            if (i == 0)
                check(sum[W-1] == (a[0] ^ b[0]), "R9 first bit at MSB",
                      {63'd0, sum[W-1]}, {63'd0, a[0] ^ b[0]});
            check(done == (i == W - 1), poke ? "R10/R3 done timing" : "R3 done timing",
                  {63'd0, done}, {63'd0, (i == W - 1)});
        end
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(done && {carry_out, sum} == ({1'b0, a} + {1'b0, b}), "R11 result held",
              {54'd0, done, carry_out, sum}, {54'd0, 1'b1, ({1'b0, a} + {1'b0, b})});
    endtask

    // Abort: a load during a run clears the carry and keeps done low.
    task automatic do_abort(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        load = 1'b1; opnd_a = a; opnd_b = b;
        @(negedge clk);
        load = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check(!carry_out && !done && sum == '0, "R2 load aborts run",
              {54'd0, done, carry_out, sum}, 64'd0);
        repeat (W + 2) @(negedge clk);
        check(!done, "R2 no done after abort", {63'd0, done}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!done && !carry_out && sum == '0, "R1 reset state",
              {54'd0, done, carry_out, sum}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !carry_out && sum == '0, "R1 idle after reset",
              {54'd0, done, carry_out, sum}, 64'd0);
        do_add(8'h00, 8'h00, 1'b0);
        do_add(8'hFF, 8'h01, 1'b0);
        do_add(8'hFF, 8'hFF, 1'b0);
        do_add(8'hAA, 8'h55, 1'b0);
        do_add(8'h80, 8'h80, 1'b0);
        do_add(8'h5A, 8'h3C, 1'b1);
        do_abort(8'hF0, 8'h0F);
        for (int k = 1; k < 6; k++)
            do_add(W'(k * 37 + 11), W'(k * 91 + 5), k[0]);
        check(exp_q.size() == 0, "R4 all results seen", {32'd0, exp_q.size()}, 64'd0);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end
endmodule